// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a down-counting watchdog that software must restart at regular intervals. A prescaler divides the clock, and each prescaler tick lowers a 16-bit counter. When a tick arrives while the counter is already at zero, the watchdog expires. The counter then reloads and keeps running. Each expiry can raise any combination of three actions: a held interrupt request, a pulse on an active-low external pin, and a one-cycle system reset request.

Software reaches the block over a simple register bus with four word addresses. Every write must carry an 8-bit access key in data bits [31:24]. The setup registers use one key value and the restart register uses another. A write with the wrong key changes no state. It sets a sticky error flag instead. This keeps code that has run off the rails from quietly disabling or feeding the watchdog.

Top module: `wdog_top`

## Requirements
- R1: After reset the external pin is high, the interrupt and reset request are low, and the status error bit is 0. The control register reads 0 and the reload register reads 0x0000FFFF.
- R2: The addresses are 0 for control, 1 for reload, 2 for restart and 3 for status. A write to address 0 or 1 needs key 0x5A in bits [31:24]. A write to address 2 needs key 0xA5. A write with a wrong key changes no register, does not reload the counter and does not clear the interrupt.
- R3: A wrong-key write to address 0, 1 or 2 sets status bit 0. The bit stays set until a correctly keyed write to one of those addresses clears it.
- R4: Control bit 0 is the enable. Once it is set, no later control write can clear it. The bit reads back as 1.
- R5: Control bits [5:4] select the prescale divisor: 0 gives 8, 1 gives 32, 2 gives 128 and 3 gives 1024 clock cycles per counter step.
- R6: Consider a keyed restart, or the first write that sets enable, with reload value R and divisor D. Expiry happens (R+1)*D cycles after the clock edge that takes the write. The counter then reloads and runs on.
- R7: With control bit 1 set, the interrupt goes high on the expiry edge. It stays high until a keyed restart clears it.
- R8: With control bit 3 set, the reset request is high for exactly the one cycle that follows the expiry edge.
- R9: With control bit 2 set, the external pin goes low on the expiry edge. It stays low for W+1 cycles, where W is control bits [15:8], giving 1 to 256 cycles.
- R10: An action whose select bit is clear stays inactive on expiry.
- R11: Status bits [31:16] show the counter and status bit 1 shows the interrupt. Just after a keyed restart the counter reads the reload value and the interrupt reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe |
| busAddr | input | 2 | Register word address |
| busWdata | input | 32 | Write data; bits [31:24] carry the key |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Held interrupt request |
| ovfPinN | output | 1 | External overflow pin, active low |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
Expiry is tried with random reload values, all four divisors, random pulse widths and random action masks, plus directed runs. The directed runs cover the shortest timeout (reload 0, divisor 8, one-cycle pulse) and the longest pulse (256 cycles). The random mask separates a fault in one action from a fault in another, and it shows that an unselected action stays quiet. The cycle before expiry and the cycle of expiry are both sampled, so an off-by-one in the prescaler or the counter shows up. Wrong-key writes target every writable address and are checked by readback, by the error bit and by an interrupt that must stay set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PULSE_BITS = 8;

  typedef struct packed {
    logic                  en;
    logic                  irqSel;
    logic                  pinSel;
    logic                  rstSel;
    logic [1:0]            preSel;
    logic [PULSE_BITS-1:0] pulseW;
  } wdCfg_t;

  typedef struct packed {
    logic reload;
    logic clrIrq;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          DATA_W     = 32,
  parameter int          KEY_W      = 8,
  parameter logic [7:0]  CTRL_KEY   = 8'h5A,
  parameter logic [7:0]  KICK_KEY   = 8'hA5,
  parameter logic [15:0] RELOAD_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              irqState,
  output logic [DATA_W-1:0] busRdata,
  output wdCfg_t            cfg,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              errFlag,
  output wdStrobe_t         stb
);
  localparam int KEY_LSB = DATA_W - KEY_W;
  localparam int CNT_LSB = DATA_W - CNT_W;

  logic [KEY_W-1:0] keyIn;
  logic keyOk, writable, goodWr, badWr;
  logic unusedBits;

  assign keyIn    = busWdata[KEY_LSB +: KEY_W];
  assign keyOk    = (busAddr == 2'd2) ? (keyIn == KICK_KEY) : (keyIn == CTRL_KEY);
  assign writable = busWr && (busAddr != 2'd3);
  assign goodWr   = writable && keyOk;
  assign badWr    = writable && !keyOk;
  assign unusedBits = ^busWdata[KEY_LSB-1:16];

  // strobes to the datapath, same cycle as the accepted write
  always_comb begin
    stb.clrIrq = goodWr && (busAddr == 2'd2);
    stb.reload = stb.clrIrq ||
                 (goodWr && (busAddr == 2'd0) && !cfg.en && busWdata[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      reloadVal <= RELOAD_RST[CNT_W-1:0];
      errFlag   <= 1'b0;
    end else begin
      if (goodWr && busAddr == 2'd0) begin
        cfg.en     <= cfg.en | busWdata[0];
        cfg.irqSel <= busWdata[1];
        cfg.pinSel <= busWdata[2];
        cfg.rstSel <= busWdata[3];
        cfg.preSel <= busWdata[5:4];
        cfg.pulseW <= busWdata[8 +: PULSE_BITS];
      end
      if (goodWr && busAddr == 2'd1)
        reloadVal <= busWdata[CNT_W-1:0];
      if (badWr)
        errFlag <= 1'b1;
      else if (goodWr)
        errFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      2'd0: begin
        busRdata[0]                = cfg.en;
        busRdata[1]                = cfg.irqSel;
        busRdata[2]                = cfg.pinSel;
        busRdata[3]                = cfg.rstSel;
        busRdata[5:4]              = cfg.preSel;
        busRdata[8 +: PULSE_BITS]  = cfg.pulseW;
      end
      2'd1: busRdata[CNT_W-1:0] = reloadVal;
      2'd3: begin
        busRdata[0]                = errFlag;
        busRdata[1]                = irqState;
        busRdata[CNT_LSB +: CNT_W] = cntVal;
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdCfg_t           cfg,
  input  wdStrobe_t        stb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             irqOut,
  output logic             rstReq,
  output logic             ovfPinN
);
  localparam int LEFT_W = PULSE_BITS + 1;

  logic [PRE_W-1:0]  preCnt, preLast;
  logic [LEFT_W-1:0] pulseLeft;
  logic tick, expire;

  always_comb begin
    case (cfg.preSel)
      2'd0:    preLast = PRE_W'(7);
      2'd1:    preLast = PRE_W'(31);
      2'd2:    preLast = PRE_W'(127);
      default: preLast = PRE_W'(1023);
    endcase
  end

  assign tick   = cfg.en && (preCnt >= preLast);
  assign expire = tick && (cntVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      cntVal    <= '0;
      irqOut    <= 1'b0;
      rstReq    <= 1'b0;
      pulseLeft <= '0;
    end else begin
      if (stb.reload) begin
        cntVal <= reloadVal;
        preCnt <= '0;
      end else if (cfg.en) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick)
          cntVal <= (cntVal == '0) ? reloadVal : cntVal - 1'b1;
      end

      if (expire && cfg.irqSel)
        irqOut <= 1'b1;
      else if (stb.clrIrq)
        irqOut <= 1'b0;

      rstReq <= expire && cfg.rstSel;

      if (expire && cfg.pinSel)
        pulseLeft <= {1'b0, cfg.pulseW} + LEFT_W'(1);
      else if (pulseLeft != '0)
        pulseLeft <= pulseLeft - 1'b1;
    end
  end

  assign ovfPinN = (pulseLeft == '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          DATA_W     = 32,
  parameter logic [7:0]  CTRL_KEY   = 8'h5A,
  parameter logic [7:0]  KICK_KEY   = 8'hA5,
  parameter logic [15:0] RELOAD_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              ovfPinN,
  output logic              rstReq
);
  wdCfg_t           cfg;
  wdStrobe_t        stb;
  logic [CNT_W-1:0] reloadVal, cntVal;
  logic             errFlag;

  wdog_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .KEY_W(8),
    .CTRL_KEY(CTRL_KEY), .KICK_KEY(KICK_KEY), .RELOAD_RST(RELOAD_RST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .cntVal(cntVal), .irqState(irqOut),
    .busRdata(busRdata), .cfg(cfg), .reloadVal(reloadVal),
    .errFlag(errFlag), .stb(stb)
  );

  wdog_dp #(.CNT_W(CNT_W), .PRE_W(10)) uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .reloadVal(reloadVal),
    .cntVal(cntVal), .irqOut(irqOut), .rstReq(rstReq), .ovfPinN(ovfPinN)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter logic [7:0] CTRL_KEY = 8'h5A,
  parameter logic [7:0] KICK_KEY = 8'hA5
) (
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busKey,
  input wdCfg_t     cfg,
  input wdStrobe_t  stb,
  input logic       errFlag,
  input logic       irqOut,
  input logic       rstReq,
  input logic       ovfPinN
);
  p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfg.en |=> cfg.en);

  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !stb.clrIrq) |=> irqOut);

  p_badkey_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != 2'd3 && busKey != CTRL_KEY && busKey != KICK_KEY) |=> errFlag);

  p_pin_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfPinN && $past(ovfPinN)) |-> $past(cfg.pinSel));

  p_rst_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(cfg.rstSel));
endmodule

bind wdog_top wdog_chk #(.CTRL_KEY(CTRL_KEY), .KICK_KEY(KICK_KEY)) uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busKey(busWdata[31:24]), .cfg(cfg), .stb(stb), .errFlag(errFlag),
  .irqOut(irqOut), .rstReq(rstReq), .ovfPinN(ovfPinN)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, ovfPinN, rstReq;
  int          vecs = 0;
  int          errs = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  wdog_top u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .ovfPinN(ovfPinN), .rstReq(rstReq)
  );

  function automatic int expDiv(input int sel);
    case (sel)
      0: return 8;
      1: return 32;
      2: return 128;
      default: return 1024;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic runExp(input int r, input int sel, input int pw, input int act);
    logic [31:0] v;
    int n;
    n = (r + 1) * expDiv(sel);
    wr(2'd2, 32'hA5000000);
    wr(2'd1, {8'h5A, 8'h00, 16'(r)});
    wr(2'd0, {8'h5A, 8'h00, 8'(pw), 2'b00, 2'(sel), act[2], act[1], act[0], 1'b1});
    wr(2'd2, 32'hA5000000);
    rd(2'd3, v);
    chk("R11 count after restart", {16'h0, v[31:16]}, r);
    chk("R11 irq cleared by restart", {31'h0, v[1]}, 0);
    for (int m = 1; m <= n + pw + 1; m++) begin
      @(negedge clk);
      #1;
      if (m == n - 1) begin
        chk("R6 R5 no expiry one cycle early irq", {31'h0, irqOut}, 0);
        chk("R6 R5 no expiry one cycle early pin", {31'h0, ovfPinN}, 1);
      end
      if (m == n) begin
        chk("R7 R10 irq at expiry", {31'h0, irqOut}, act[0]);
        chk("R9 R10 pin at expiry", {31'h0, ovfPinN}, !act[1]);
        chk("R8 R10 reset request at expiry", {31'h0, rstReq}, act[2]);
      end
      if (m == n + 1)
        chk("R8 reset request lasts one cycle", {31'h0, rstReq}, 0);
      if (act[1] && m == n + pw)
        chk("R9 pin still low at last pulse cycle", {31'h0, ovfPinN}, 0);
      if (act[1] && m == n + pw + 1)
        chk("R9 pin released after pulse", {31'h0, ovfPinN}, 1);
      if (!act[1] && m > n + 1) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pin idle high", {31'h0, ovfPinN}, 1);
    chk("R1 irq low", {31'h0, irqOut}, 0);
    chk("R1 reset request low", {31'h0, rstReq}, 0);
    rd(2'd0, v); chk("R1 control reset", v, 0);
    rd(2'd1, v); chk("R1 reload reset", v, 32'h0000FFFF);
    rd(2'd3, v); chk("R1 error bit reset", {31'h0, v[0]}, 0);

    wr(2'd0, 32'h3300000F);
    rd(2'd0, v); chk("R2 bad key control ignored", v, 0);
    rd(2'd3, v); chk("R3 bad key sets error", {31'h0, v[0]}, 1);
    wr(2'd1, 32'hA5001234);
    rd(2'd1, v); chk("R2 wrong key on reload ignored", v, 32'h0000FFFF);
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R3 error stays set", {31'h0, v[0]}, 1);
    wr(2'd1, 32'h5A000007);
    rd(2'd3, v); chk("R3 good write clears error", {31'h0, v[0]}, 0);
    rd(2'd1, v); chk("R2 good key reload written", v, 32'h7);

    runExp(0, 0, 0, 7);
    runExp(2, 2, 255, 2);
    for (int i = 0; i < 10; i++) begin
      int r, sel, n, pw, lim;
      r = $urandom % 9;
      sel = $urandom % 4;
      n = (r + 1) * expDiv(sel);
      lim = (n - 1 > 256) ? 256 : n - 1;
      pw = $urandom % lim;
      runExp(r, sel, pw, $urandom % 8);
    end

    runExp(1, 0, 3, 1);
    chk("R7 irq held after expiry", {31'h0, irqOut}, 1);
    wr(2'd2, 32'h5A000000);
    @(negedge clk);
    chk("R2 wrong key restart keeps irq", {31'h0, irqOut}, 1);
    rd(2'd3, v); chk("R3 wrong key restart sets error", {31'h0, v[0]}, 1);
    wr(2'd0, 32'h5A000000);
    rd(2'd0, v); chk("R4 enable cannot be cleared", {31'h0, v[0]}, 1);
    rd(2'd3, v); chk("R3 keyed control write clears error", {31'h0, v[0]}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule